// File: doc/BRIEF.md
# Dual-View Peripheral Protection Configuration

This block holds the security setup for a set of peripheral protection checkers arranged in three groups: an AHB expansion group, an APB internal group and an APB expansion group. For every port of every checker it stores three mask bits: a non-secure bit, a privilege bit for secure accesses and a privilege bit for non-secure accesses. From these it drives two levels per port. The first tells the checker whether the port is non-secure. The second gives the privilege requirement, and the port's own security bit decides which of the two privilege bits supplies it.

Software reaches the block through two APB register windows that share one set of address, data and control wires but have separate select inputs. The secure window sets the non-secure masks, the secure-side privilege masks and two small configuration fields: the secure response setting and the non-secure-callable setting. Each field drives an output pin. The non-secure window reaches only the non-secure-side privilege masks. It sits at the same offsets that the secure-side privilege masks use in the secure window. Both windows serve a read-only block of identification bytes.

Top module: `secctl_ppc_cfg`

## Requirements
- R1: After reset every mask of every checker, the response field and the callable field read zero, and all pin outputs are low.
- R2: A mask write keeps only the low bits that match the checker's port count (EXP_PORTS for both expansion groups, INT_PORTS for the internal group). Higher data bits are dropped.
- R3: Bit c*P+p of a group's nonsec output (P = ports per checker) equals non-secure mask bit p of checker c in that group.
- R4: Bit c*P+p of a group's priv output equals the non-secure-side privilege bit when the non-secure bit of that port is 1, and the secure-side privilege bit when it is 0. It follows any mask write on the clock edge that commits the write.
- R5: Secure window, with the checker index taken from paddr[3:2]: non-secure masks at 0x60-0x6C (AHB expansion), 0x70-0x74 (APB internal) and 0x80-0x8C (APB expansion). Secure-side privilege masks at 0xA0-0xAC, 0xB0-0xB4 and 0xC0-0xCC. An index at or above a group's checker count is unmapped.
- R6: Non-secure window: non-secure-side privilege masks at 0xA0-0xAC, 0xB0-0xB4 and 0xC0-0xCC. No other offset in this window accepts a write. 0x90 reads zero.
- R7: Secure window 0x10 holds a 1-bit response field (data bit 0) driving resp_cfg_o. 0x14 holds a 2-bit callable field (data bits 1:0) driving nsc_cfg_o. Both pins change on the edge that commits the write.
- R8: The twelve word offsets 0xFD0 to 0xFFC each return one byte, in this offset order: 04 00 00 00 xx B8 0B 00 0D F0 05 B1. At 0xFE0, xx is 0x52 in the secure window and 0x53 in the non-secure window.
- R9: psize encodes 00 byte, 01 halfword, 1x word. A write takes effect only when psize is a word. Byte and halfword writes change nothing.
- R10: A word read returns the whole register and ignores paddr[1:0]. A byte or halfword read returns the register shifted right by 8*paddr[1:0], masked to 8 or 16 bits.
- R11: Unmapped offsets, 0x50 and 0x90 read zero and ignore writes. pready is always 1 and pslverr always 0.
- R12: When psel_s and psel_ns are both high, the secure window serves the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel_s | input | 1 | Select for the secure window |
| psel_ns | input | 1 | Select for the non-secure window |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte offset within the window |
| psize | input | 2 | Access size: 00 byte, 01 half, 1x word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| resp_cfg_o | output | 1 | Secure response setting |
| nsc_cfg_o | output | 2 | Non-secure-callable setting |
| ahbx_nonsec_o | output | AHBX_CKRS*EXP_PORTS | AHB expansion non-secure levels |
| ahbx_priv_o | output | AHBX_CKRS*EXP_PORTS | AHB expansion privilege levels |
| apbi_nonsec_o | output | APBI_CKRS*INT_PORTS | APB internal non-secure levels |
| apbi_priv_o | output | APBI_CKRS*INT_PORTS | APB internal privilege levels |
| apbx_nonsec_o | output | APBX_CKRS*EXP_PORTS | APB expansion non-secure levels |
| apbx_priv_o | output | APBX_CKRS*EXP_PORTS | APB expansion privilege levels |

## Verification
The bench probes the shared offsets 0xA0-0xCC from both windows. A design that mixed up the windows would let a non-secure write land in a secure-side privilege mask, or would never drive priv from the non-secure-side mask. It flips non-secure bits under fixed privilege masks so that a priv output wired to only one mask shows up at once. It writes all-ones to the 4-port internal checkers, writes to their absent index 2 and 3 slots, sends byte and halfword writes, and makes narrow reads at every lane. A design that skipped truncation, aliased the index, took narrow writes or shifted lanes the wrong way would return the wrong read data or move a pin. It also drives both selects together and reads the 0xFE0 identification byte in each window.

// File: rtl/secctl_pkg.sv
package secctl_pkg;

  // Access size encoding on psize
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } xfer_size_e;

  // 16-byte block codes taken from paddr[11:4]
  localparam logic [7:0] BLK_CFG       = 8'h01;
  localparam logic [7:0] BLK_AHBX_NS   = 8'h06;
  localparam logic [7:0] BLK_APBI_NS   = 8'h07;
  localparam logic [7:0] BLK_APBX_NS   = 8'h08;
  localparam logic [7:0] BLK_AHBX_PRIV = 8'h0A;
  localparam logic [7:0] BLK_APBI_PRIV = 8'h0B;
  localparam logic [7:0] BLK_APBX_PRIV = 8'h0C;
  localparam logic [7:0] BLK_ID_LO     = 8'hFD;
  localparam logic [7:0] BLK_ID_MID    = 8'hFE;
  localparam logic [7:0] BLK_ID_HI     = 8'hFF;

  localparam int unsigned NSC_W = 2;

  // Identification byte k (0..11 from 0xFD0 upward) for either window
  function automatic logic [7:0] id_byte(input logic [3:0] k, input logic ns_view);
    logic [7:0] b;
    case (k)
      4'd0:    b = 8'h04;
      4'd4:    b = ns_view ? 8'h53 : 8'h52;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/secctl_apb_front.sv
module secctl_apb_front
  import secctl_pkg::*;
(
  input  logic        psel_s,
  input  logic        psel_ns,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [1:0]  psize,
  input  logic [1:0]  pa_lo,
  input  logic [31:0] word_rd,
  output logic        view_ns,
  output logic        wr_s,
  output logic        wr_ns,
  output logic [31:0] prdata
);

  logic        access;
  logic        word_wr;
  logic [31:0] shifted;

  // Secure select has priority when both are raised
  assign view_ns = psel_ns && !psel_s;
  assign access  = (psel_s || psel_ns) && penable;
  assign word_wr = access && pwrite && psize[1];
  assign wr_s    = word_wr && !view_ns;
  assign wr_ns   = word_wr && view_ns;

  // Narrow reads: shift the addressed lanes down, then mask
  assign shifted = word_rd >> {pa_lo, 3'b000};

  always_comb begin
    if (psize[1])                       prdata = word_rd;
    else if (psize == SZ_HALF)          prdata = {16'h0000, shifted[15:0]};
    else                                prdata = {24'h000000, shifted[7:0]};
  end

endmodule

// File: rtl/secctl_cfg.sv
module secctl_cfg
  import secctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_resp,
  input  logic             we_nsc,
  input  logic [31:0]      wdata,
  output logic             resp_q,
  output logic [NSC_W-1:0] nsc_q
);

  logic             resp_d;
  logic [NSC_W-1:0] nsc_d;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[31:NSC_W];

  always_comb begin
    resp_d = resp_q;
    nsc_d  = nsc_q;
    if (we_resp) resp_d = wdata[0];
    if (we_nsc)  nsc_d  = wdata[NSC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= 1'b0;
      nsc_q  <= '0;
    end else begin
      if (we_resp) resp_q <= resp_d;
      if (we_nsc)  nsc_q  <= nsc_d;
    end
  end

endmodule

// File: rtl/secctl_ckr_group.sv
module secctl_ckr_group #(
  parameter int unsigned N_CKR  = 4,
  parameter int unsigned N_PORT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_ns,
  input  logic                    we_sp,
  input  logic                    we_nsp,
  input  logic [1:0]              idx,
  input  logic [31:0]             wdata,
  output logic [31:0]             rd_ns,
  output logic [31:0]             rd_sp,
  output logic [31:0]             rd_nsp,
  output logic [N_CKR*N_PORT-1:0] nonsec_o,
  output logic [N_CKR*N_PORT-1:0] priv_o
);

  localparam int unsigned TOT = N_CKR * N_PORT;

  logic [N_PORT-1:0] ns_q  [N_CKR];
  logic [N_PORT-1:0] sp_q  [N_CKR];
  logic [N_PORT-1:0] nsp_q [N_CKR];
  logic [N_PORT-1:0] ns_d  [N_CKR];
  logic [N_PORT-1:0] sp_d  [N_CKR];
  logic [N_PORT-1:0] nsp_d [N_CKR];
  logic              sel_ok;
  logic              upd_en;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign sel_ok = (32'(idx) < N_CKR);
  assign upd_en = (we_ns || we_sp || we_nsp) && sel_ok;

  // Next state: only the indexed checker takes the truncated data
  always_comb begin
    for (int c = 0; c < int'(N_CKR); c++) begin
      ns_d[c]  = ns_q[c];
      sp_d[c]  = sp_q[c];
      nsp_d[c] = nsp_q[c];
      if (sel_ok && idx == 2'(c)) begin
        if (we_ns)  ns_d[c]  = wdata[N_PORT-1:0];
        if (we_sp)  sp_d[c]  = wdata[N_PORT-1:0];
        if (we_nsp) nsp_d[c] = wdata[N_PORT-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < int'(N_CKR); c++) begin
        ns_q[c]  <= '0;
        sp_q[c]  <= '0;
        nsp_q[c] <= '0;
      end
    end else if (upd_en) begin
      for (int c = 0; c < int'(N_CKR); c++) begin
        ns_q[c]  <= ns_d[c];
        sp_q[c]  <= sp_d[c];
        nsp_q[c] <= nsp_d[c];
      end
    end
  end

  // Readback of the indexed checker; absent index reads zero
  always_comb begin
    rd_ns  = '0;
    rd_sp  = '0;
    rd_nsp = '0;
    for (int c = 0; c < int'(N_CKR); c++) begin
      if (sel_ok && idx == 2'(c)) begin
        rd_ns  = 32'(ns_q[c]);
        rd_sp  = 32'(sp_q[c]);
        rd_nsp = 32'(nsp_q[c]);
      end
    end
  end

  // Per-port outputs
  for (genvar c = 0; c < N_CKR; c++) begin : g_ckr
    for (genvar p = 0; p < N_PORT; p++) begin : g_port
      assign nonsec_o[c*N_PORT+p] = ns_q[c][p];
      assign priv_o[c*N_PORT+p]   = ns_q[c][p] ? nsp_q[c][p] : sp_q[c][p];
    end
  end

  // R4: with no mask write the priv levels cannot move
  a_r4_priv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_ns || we_sp || we_nsp) |=> $stable(priv_o));

  // R3: nonsec levels move only after a non-secure mask write
  a_r3_nonsec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ns |=> $stable(nonsec_o));

  // R5: a write to an absent checker index leaves every level alone
  a_r5_absent_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> $stable(nonsec_o) && $stable(priv_o));

  initial begin
    a_r2_width: assert (N_PORT >= 1 && N_PORT <= 32 && N_CKR <= 4 && TOT > 0);
  end

endmodule

// File: rtl/secctl_ppc_cfg.sv
module secctl_ppc_cfg
  import secctl_pkg::*;
#(
  parameter int unsigned AHBX_CKRS = 4,
  parameter int unsigned APBI_CKRS = 2,
  parameter int unsigned APBX_CKRS = 4,
  parameter int unsigned EXP_PORTS = 16,
  parameter int unsigned INT_PORTS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           psel_s,
  input  logic                           psel_ns,
  input  logic                           penable,
  input  logic                           pwrite,
  input  logic [11:0]                    paddr,
  input  logic [1:0]                     psize,
  input  logic [31:0]                    pwdata,
  output logic [31:0]                    prdata,
  output logic                           pready,
  output logic                           pslverr,
  output logic                           resp_cfg_o,
  output logic [1:0]                     nsc_cfg_o,
  output logic [AHBX_CKRS*EXP_PORTS-1:0] ahbx_nonsec_o,
  output logic [AHBX_CKRS*EXP_PORTS-1:0] ahbx_priv_o,
  output logic [APBI_CKRS*INT_PORTS-1:0] apbi_nonsec_o,
  output logic [APBI_CKRS*INT_PORTS-1:0] apbi_priv_o,
  output logic [APBX_CKRS*EXP_PORTS-1:0] apbx_nonsec_o,
  output logic [APBX_CKRS*EXP_PORTS-1:0] apbx_priv_o
);

  logic [7:0]  blk;
  logic [1:0]  sub;
  logic        view_ns;
  logic        wr_s;
  logic        wr_ns;
  logic [31:0] word_rd;
  logic [3:0]  id_k;

  logic [31:0] ahbx_rns, ahbx_rsp, ahbx_rnsp;
  logic [31:0] apbi_rns, apbi_rsp, apbi_rnsp;
  logic [31:0] apbx_rns, apbx_rsp, apbx_rnsp;

  assign blk     = paddr[11:4];
  assign sub     = paddr[3:2];
  assign id_k    = {blk[1:0] - 2'd1, sub};
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  secctl_apb_front u_front (
    .psel_s  (psel_s),
    .psel_ns (psel_ns),
    .penable (penable),
    .pwrite  (pwrite),
    .psize   (psize),
    .pa_lo   (paddr[1:0]),
    .word_rd (word_rd),
    .view_ns (view_ns),
    .wr_s    (wr_s),
    .wr_ns   (wr_ns),
    .prdata  (prdata)
  );

  secctl_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_resp (wr_s && blk == BLK_CFG && sub == 2'd0),
    .we_nsc  (wr_s && blk == BLK_CFG && sub == 2'd1),
    .wdata   (pwdata),
    .resp_q  (resp_cfg_o),
    .nsc_q   (nsc_cfg_o)
  );

  secctl_ckr_group #(.N_CKR(AHBX_CKRS), .N_PORT(EXP_PORTS)) u_ahbx (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_ns    (wr_s  && blk == BLK_AHBX_NS),
    .we_sp    (wr_s  && blk == BLK_AHBX_PRIV),
    .we_nsp   (wr_ns && blk == BLK_AHBX_PRIV),
    .idx      (sub),
    .wdata    (pwdata),
    .rd_ns    (ahbx_rns),
    .rd_sp    (ahbx_rsp),
    .rd_nsp   (ahbx_rnsp),
    .nonsec_o (ahbx_nonsec_o),
    .priv_o   (ahbx_priv_o)
  );

  secctl_ckr_group #(.N_CKR(APBI_CKRS), .N_PORT(INT_PORTS)) u_apbi (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_ns    (wr_s  && blk == BLK_APBI_NS),
    .we_sp    (wr_s  && blk == BLK_APBI_PRIV),
    .we_nsp   (wr_ns && blk == BLK_APBI_PRIV),
    .idx      (sub),
    .wdata    (pwdata),
    .rd_ns    (apbi_rns),
    .rd_sp    (apbi_rsp),
    .rd_nsp   (apbi_rnsp),
    .nonsec_o (apbi_nonsec_o),
    .priv_o   (apbi_priv_o)
  );

  secctl_ckr_group #(.N_CKR(APBX_CKRS), .N_PORT(EXP_PORTS)) u_apbx (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_ns    (wr_s  && blk == BLK_APBX_NS),
    .we_sp    (wr_s  && blk == BLK_APBX_PRIV),
    .we_nsp   (wr_ns && blk == BLK_APBX_PRIV),
    .idx      (sub),
    .wdata    (pwdata),
    .rd_ns    (apbx_rns),
    .rd_sp    (apbx_rsp),
    .rd_nsp   (apbx_rnsp),
    .nonsec_o (apbx_nonsec_o),
    .priv_o   (apbx_priv_o)
  );

  // Read mux per window; everything not listed reads zero
  always_comb begin
    word_rd = '0;
    if (view_ns) begin
      case (blk)
        BLK_AHBX_PRIV: word_rd = ahbx_rnsp;
        BLK_APBI_PRIV: word_rd = apbi_rnsp;
        BLK_APBX_PRIV: word_rd = apbx_rnsp;
        BLK_ID_LO, BLK_ID_MID, BLK_ID_HI:
                       word_rd = {24'h0, id_byte(id_k, 1'b1)};
        default:       word_rd = '0;
      endcase
    end else begin
      case (blk)
        BLK_CFG: begin
          if (sub == 2'd0)      word_rd = {31'h0, resp_cfg_o};
          else if (sub == 2'd1) word_rd = {30'h0, nsc_cfg_o};
        end
        BLK_AHBX_NS:   word_rd = ahbx_rns;
        BLK_APBI_NS:   word_rd = apbi_rns;
        BLK_APBX_NS:   word_rd = apbx_rns;
        BLK_AHBX_PRIV: word_rd = ahbx_rsp;
        BLK_APBI_PRIV: word_rd = apbi_rsp;
        BLK_APBX_PRIV: word_rd = apbx_rsp;
        BLK_ID_LO, BLK_ID_MID, BLK_ID_HI:
                       word_rd = {24'h0, id_byte(id_k, 1'b0)};
        default:       word_rd = '0;
      endcase
    end
  end

  // R9: a narrow write leaves every pin unchanged
  a_r9_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((psel_s || psel_ns) && penable && pwrite && !psize[1]) |=>
      $stable(resp_cfg_o) && $stable(nsc_cfg_o) && $stable(ahbx_nonsec_o) &&
      $stable(apbi_nonsec_o) && $stable(apbx_nonsec_o) && $stable(ahbx_priv_o) &&
      $stable(apbi_priv_o) && $stable(apbx_priv_o));

  // R6: the non-secure window never reaches non-secure masks or config fields
  a_r6_ns_view_limited: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_ns && !psel_s && penable && pwrite) |=>
      $stable(resp_cfg_o) && $stable(nsc_cfg_o) && $stable(ahbx_nonsec_o) &&
      $stable(apbi_nonsec_o) && $stable(apbx_nonsec_o));

  // R7: a word write to 0x14 in the secure window loads the callable field
  a_r7_nsc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_s && penable && pwrite && psize[1] && paddr[11:2] == 10'h005) |=>
      nsc_cfg_o == $past(pwdata[1:0]));

  // R11: with no transfer in its access phase nothing changes
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !((psel_s || psel_ns) && penable) |=>
      $stable(resp_cfg_o) && $stable(nsc_cfg_o) && $stable(apbx_priv_o));

endmodule

// File: tb/secctl_ppc_cfg_bench.sv
module secctl_ppc_cfg_bench;

  localparam int NG = 3;
  localparam int TOTW = 1 + 2 + 64 + 64 + 8 + 8 + 64 + 64 + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel_s = 1'b0, psel_ns = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [1:0]  psize = 2'b10;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, resp_cfg_o;
  logic [1:0]  nsc_cfg_o;
  logic [63:0] ahbx_nonsec_o, ahbx_priv_o, apbx_nonsec_o, apbx_priv_o;
  logic [7:0]  apbi_nonsec_o, apbi_priv_o;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  // Reference state: group 0 AHB exp, 1 APB int, 2 APB exp
  logic [31:0] m_ns  [NG][4];
  logic [31:0] m_sp  [NG][4];
  logic [31:0] m_nsp [NG][4];
  logic        m_resp;
  logic [1:0]  m_nsc;
  int          n_ck [NG] = '{4, 2, 4};
  int          n_pt [NG] = '{16, 4, 16};
  logic [7:0]  id_tab [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h52, 8'hB8,
                                8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #4 clk = ~clk;

  secctl_ppc_cfg u_secctl_ppc_cfg (
    .clk(clk), .rst_n(rst_n), .psel_s(psel_s), .psel_ns(psel_ns),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .psize(psize),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .resp_cfg_o(resp_cfg_o), .nsc_cfg_o(nsc_cfg_o),
    .ahbx_nonsec_o(ahbx_nonsec_o), .ahbx_priv_o(ahbx_priv_o),
    .apbi_nonsec_o(apbi_nonsec_o), .apbi_priv_o(apbi_priv_o),
    .apbx_nonsec_o(apbx_nonsec_o), .apbx_priv_o(apbx_priv_o)
  );

  task automatic model_reset();
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < 4; i++) begin
        m_ns[g][i] = 0; m_sp[g][i] = 0; m_nsp[g][i] = 0;
      end
    m_resp = 0; m_nsc = 0;
  endtask

  task automatic model_write(input bit s, input bit ns, input logic [11:0] a,
                             input logic [1:0] sz, input logic [31:0] d);
    int blk, i;
    logic [31:0] msk;
    if (!sz[1]) return;
    blk = int'(a[11:4]); i = int'(a[3:2]);
    for (int g = 0; g < NG; g++) begin
      msk = (n_pt[g] == 32) ? 32'hFFFF_FFFF : ((32'd1 << n_pt[g]) - 1);
      if (i < n_ck[g]) begin
        if (s && blk == 6 + g)        m_ns[g][i]  = d & msk;
        if (s && blk == 10 + g)       m_sp[g][i]  = d & msk;
        if (!s && ns && blk == 10 + g) m_nsp[g][i] = d & msk;
      end
    end
    if (s && blk == 1 && i == 0) m_resp = d[0];
    if (s && blk == 1 && i == 1) m_nsc  = d[1:0];
  endtask

  function automatic logic [31:0] model_read(input bit s, input logic [11:0] a,
                                             input logic [1:0] sz);
    int blk, i;
    logic [31:0] w, sh;
    blk = int'(a[11:4]); i = int'(a[3:2]);
    w = 0;
    for (int g = 0; g < NG; g++) begin
      if (i < n_ck[g]) begin
        if (s && blk == 6 + g)   w = m_ns[g][i];
        if (s && blk == 10 + g)  w = m_sp[g][i];
        if (!s && blk == 10 + g) w = m_nsp[g][i];
      end
    end
    if (s && blk == 1 && i == 0) w = {31'h0, m_resp};
    if (s && blk == 1 && i == 1) w = {30'h0, m_nsc};
    if (blk >= 8'hFD) begin
      w = {24'h0, id_tab[(blk - 8'hFD) * 4 + i]};
      if (!s && (blk - 8'hFD) * 4 + i == 4) w = 32'h53;
    end
    if (sz[1]) return w;
    sh = w >> (8 * int'(a[1:0]));
    return (sz == 2'b01) ? (sh & 32'hFFFF) : (sh & 32'hFF);
  endfunction

  function automatic logic [TOTW-1:0] exp_pins();
    logic [63:0] ans, apr, xns, xpr;
    logic [7:0]  ins, ipr;
    ans = 0; apr = 0; xns = 0; xpr = 0; ins = 0; ipr = 0;
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 16; p++) begin
        ans[c*16+p] = m_ns[0][c][p];
        apr[c*16+p] = m_ns[0][c][p] ? m_nsp[0][c][p] : m_sp[0][c][p];
        xns[c*16+p] = m_ns[2][c][p];
        xpr[c*16+p] = m_ns[2][c][p] ? m_nsp[2][c][p] : m_sp[2][c][p];
      end
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 4; p++) begin
        ins[c*4+p] = m_ns[1][c][p];
        ipr[c*4+p] = m_ns[1][c][p] ? m_nsp[1][c][p] : m_sp[1][c][p];
      end
    return {m_resp, m_nsc, ans, apr, ins, ipr, xns, xpr, 1'b1, 1'b0};
  endfunction

  // Every-clock comparison of all pins (R1 R3 R4 R7 R11)
  always @(negedge clk) begin
    if (live) begin
      logic [TOTW-1:0] act, ex;
      act = {resp_cfg_o, nsc_cfg_o, ahbx_nonsec_o, ahbx_priv_o, apbi_nonsec_o,
             apbi_priv_o, apbx_nonsec_o, apbx_priv_o, pready, pslverr};
      ex = exp_pins();
      checks++;
      if (act !== ex) begin
        errors++;
        $display("FAIL R3/R4/R7/R11 pins act=%h exp=%h t=%0t", act, ex, $time);
      end
    end
  end

  task automatic xfer(input bit s, input bit ns, input bit wr, input logic [11:0] a,
                      input logic [1:0] sz, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    psel_s = s; psel_ns = ns; penable = 0; pwrite = wr;
    paddr = a; psize = sz; pwdata = d;
    @(negedge clk);
    penable = 1;
    #2 r = prdata;
    @(posedge clk);
    if (wr) model_write(s, ns, a, sz, d);
    #1 psel_s = 0; psel_ns = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input bit s, input bit ns, input logic [11:0] a,
                    input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r;
    xfer(s, ns, 1'b1, a, sz, d, r);
  endtask

  task automatic rd(input bit s, input bit ns, input logic [11:0] a,
                    input logic [1:0] sz, input string tag);
    logic [31:0] r, e;
    xfer(s, ns, 1'b0, a, sz, 32'h0, r);
    e = model_read(s, a, sz);
    checks++;
    if (r !== e) begin
      errors++;
      $display("FAIL %s read addr=%h view_s=%0d act=%h exp=%h", tag, a, s, r, e);
    end
  endtask

  task automatic rd_const(input bit s, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] e, input string tag);
    logic [31:0] r;
    xfer(s, !s, 1'b0, a, sz, 32'h0, r);
    checks++;
    if (r !== e) begin
      errors++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, a, r, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;

    // R1: reset values
    rd(1, 0, 12'h060, 2'b10, "R1");
    rd(1, 0, 12'h0B4, 2'b10, "R1");
    rd(0, 1, 12'h0C8, 2'b10, "R1");
    rd(1, 0, 12'h014, 2'b10, "R1");

    // R7: config fields and pin drive
    wr(1, 0, 12'h010, 2'b10, 32'hFFFF_FFFF);
    wr(1, 0, 12'h014, 2'b10, 32'hFFFF_FFFE);
    rd(1, 0, 12'h010, 2'b10, "R7");
    rd_const(1, 12'h014, 2'b10, 32'h2, "R7 nsc");

    // R2: truncation to port count
    wr(1, 0, 12'h068, 2'b10, 32'h1234_ABCD);
    rd_const(1, 12'h068, 2'b10, 32'h0000_ABCD, "R2 exp16");
    wr(1, 0, 12'h074, 2'b10, 32'hFFFF_FFFF);
    rd_const(1, 12'h074, 2'b10, 32'h0000_000F, "R2 int4");

    // R5: absent internal index 2 is unmapped
    wr(1, 0, 12'h078, 2'b10, 32'hFFFF_FFFF);
    rd_const(1, 12'h078, 2'b10, 32'h0, "R5 absent idx");
    rd_const(1, 12'h070, 2'b10, 32'h0, "R5 idx0 untouched");

    // R4: priv selection with fixed privilege masks, flipping nonsec bits
    wr(1, 0, 12'h0C4, 2'b10, 32'h0000_00F0);
    wr(0, 1, 12'h0C4, 2'b10, 32'h0000_0F00);
    wr(1, 0, 12'h084, 2'b10, 32'h0000_0000);
    wr(1, 0, 12'h084, 2'b10, 32'h0000_FFFF);
    wr(1, 0, 12'h084, 2'b10, 32'h0000_0F0F);
    rd(0, 1, 12'h0C4, 2'b10, "R4 nsp");
    rd(1, 0, 12'h0C4, 2'b10, "R4 sp");

    // R6: non-secure window cannot reach secure fields
    wr(0, 1, 12'h060, 2'b10, 32'hFFFF_FFFF);
    wr(0, 1, 12'h010, 2'b10, 32'h0);
    wr(0, 1, 12'h090, 2'b10, 32'hFFFF_FFFF);
    rd_const(1, 12'h060, 2'b10, 32'h0, "R6 ns mask untouched");
    rd_const(0, 12'h090, 2'b10, 32'h0, "R6 raz");
    rd_const(1, 12'h010, 2'b10, 32'h1, "R6 resp kept");

    // R9: narrow writes ignored
    wr(1, 0, 12'h014, 2'b00, 32'h0);
    wr(1, 0, 12'h080, 2'b01, 32'hFFFF_FFFF);
    rd_const(1, 12'h014, 2'b10, 32'h2, "R9 byte write");
    rd_const(1, 12'h080, 2'b10, 32'h0, "R9 half write");

    // R10: narrow read lanes
    wr(1, 0, 12'h06C, 2'b10, 32'h0000_BEEF);
    rd_const(1, 12'h06D, 2'b00, 32'hBE, "R10 byte lane1");
    rd_const(1, 12'h06C, 2'b01, 32'hBEEF, "R10 half lane0");
    rd_const(1, 12'h06E, 2'b01, 32'h0, "R10 half lane2");
    rd_const(1, 12'h06F, 2'b10, 32'hBEEF, "R10 word ignores low bits");

    // R8: identification bytes
    rd_const(1, 12'hFE0, 2'b10, 32'h52, "R8 secure");
    rd_const(0, 12'hFE0, 2'b10, 32'h53, "R8 nonsecure");
    rd_const(0, 12'hFFC, 2'b10, 32'hB1, "R8 last");
    rd(1, 0, 12'hFD0, 2'b10, "R8");

    // R11: read-as-zero and unmapped offsets
    wr(1, 0, 12'h050, 2'b10, 32'hFFFF_FFFF);
    rd_const(1, 12'h050, 2'b10, 32'h0, "R11 raz 0x50");
    rd_const(1, 12'h300, 2'b10, 32'h0, "R11 unmapped");

    // R12: both selects, secure wins
    wr(1, 1, 12'h0A0, 2'b10, 32'h0000_5A5A);
    rd_const(1, 12'h0A0, 2'b10, 32'h5A5A, "R12 secure took write");
    rd_const(0, 12'h0A0, 2'b10, 32'h0, "R12 nsp untouched");

    // Mixed traffic against the reference (R5 R6 R10)
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  b;
      logic [11:0] a;
      int k, sv;
      bit s, ns;
      k = $urandom % 12;
      case (k)
        0: b = 8'h01; 1: b = 8'h05; 2: b = 8'h06; 3: b = 8'h07;
        4: b = 8'h08; 5: b = 8'h09; 6: b = 8'h0A; 7: b = 8'h0B;
        8: b = 8'h0C; 9: b = 8'hFD; 10: b = 8'hFE; default: b = 8'hFF;
      endcase
      a = {b, 4'($urandom)};
      sv = $urandom % 3;
      s = (sv != 1); ns = (sv != 0);
      if ($urandom % 2) wr(s, ns, a, 2'($urandom), $urandom);
      else              rd(s, ns, a, 2'($urandom), "R5/R6/R10 mixed");
    end

    live = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule